// File: doc/BRIEF.md
# Multi-Lane Video Raster Timing Generator

This block produces the real-time timing of a video raster, progressive or interlaced, at a rate of several pixels per clock. Every clock it presents one word made of `LANES` pixel positions. Each lane gets a control word (active, start of line, start of frame, end of line) and the legacy field, vertical and horizontal flags. The line length need not be a multiple of the lane count, so a line may end in the middle of a word. The next line then starts in the following lane of that same word.

The raster geometry comes from build-time defaults. Software can rewrite it at run time through a small write-only register port. Writes land in a shadow copy, which becomes the working copy at the clock that wraps the frame, so the output never changes geometry partway through a frame. An external lock controller can drive `restart` to jump the raster to a programmed coordinate on the next clock. A build option `ALIGNED` removes the in-word line-wrap logic for the lanes when all horizontal timing values are multiples of `LANES`.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset the word starts at pixel 0, line 0, field 0, so lane 0 carries active, start-of-line and start-of-frame (control word 4'b0111 with the default geometry).
- R2: Lane k shows pixel base+k. When that index reaches the line total it wraps to pixel 0 of the next line inside the same word, and a word holds at most one start-of-line lane.
- R3: Control bit 0 (active) is set when pixel < active width and line < active height.
- R4: The H flag of a lane is set when hsync start <= pixel < hsync end.
- R5: The V flag of a lane is set when vsync start <= line < vsync end, using that lane's own line.
- R6: Control bit 1 is set at pixel 0. Bit 2 is set at pixel 0 of line 0 of field 0. Bit 3 is set at pixel total-1.
- R7: In progressive mode the line wraps to 0 after field-0 line total lines, and the F flag stays 0.
- R8: In interlaced mode fields alternate, with field-0 and field-1 line totals. F equals field XOR (line >= F toggle line).
- R9: A write (address: 0 line total, 1 active width, 2 hsync start, 3 hsync end, 4 field-0 lines, 5 field-1 lines, 6 active height, 7 vsync start, 8 vsync end, 9 F toggle line, 10 interlaced in bit 0, 11 restart pixel, 12 restart line) changes only the shadow copy. The shadow becomes the working geometry at the clock edge on which the raster wraps back to line 0 of field 0, unless `restart` is high at that edge.
- R10: With `restart` high at a clock edge, the next word's base position is (restart pixel, restart line) in field 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | CW | Register write data |
| restart | input | 1 | Jump to restart coordinate on next clock |
| ctrl_word | output | LANES*4 | Per-lane control word, lane k at bits 4k+3:4k |
| f_flag | output | LANES | Per-lane field flag |
| v_flag | output | LANES | Per-lane vertical sync flag |
| h_flag | output | LANES | Per-lane horizontal sync flag |

## Verification
A wrong base counter shifts every lane's flags at once. The mismatch appears in the first word after the fault and stays there, because the error carries into every later word. A wrong in-word wrap shows only in the words that cross a line end, as a start-of-line or end-of-line bit in the wrong lane. A commit at the wrong edge shows as old or new geometry one word early or late around the frame wrap. A field error shows within one field as a wrong F flag or a wrong field length.

// File: rtl/raster_timing_pkg.sv
package raster_timing_pkg;

    parameter int CW = 12;

    localparam int CTRL_W   = 4;
    localparam int CTRL_ACT = 0;
    localparam int CTRL_SOL = 1;
    localparam int CTRL_SOF = 2;
    localparam int CTRL_EOL = 3;

    typedef enum logic [3:0] {
        REG_HTOT   = 4'd0,
        REG_HACT   = 4'd1,
        REG_HS_BEG = 4'd2,
        REG_HS_END = 4'd3,
        REG_VTOT0  = 4'd4,
        REG_VTOT1  = 4'd5,
        REG_VACT   = 4'd6,
        REG_VS_BEG = 4'd7,
        REG_VS_END = 4'd8,
        REG_FLINE  = 4'd9,
        REG_MODE   = 4'd10,
        REG_RST_H  = 4'd11,
        REG_RST_V  = 4'd12
    } reg_addr_e;

    typedef struct packed {
        logic [CW-1:0] pix;
        logic [CW-1:0] line;
        logic          fld;
    } pos_t;

    typedef struct packed {
        logic [CW-1:0] htot;
        logic [CW-1:0] hact;
        logic [CW-1:0] hs_beg;
        logic [CW-1:0] hs_end;
        logic [CW-1:0] vtot0;
        logic [CW-1:0] vtot1;
        logic [CW-1:0] vact;
        logic [CW-1:0] vs_beg;
        logic [CW-1:0] vs_end;
        logic [CW-1:0] fline;
        logic          interlaced;
        logic [CW-1:0] rst_h;
        logic [CW-1:0] rst_v;
    } cfg_t;

endpackage

// File: rtl/rtg_cfg_regs.sv
module rtg_cfg_regs
    import raster_timing_pkg::*;
#(
    parameter cfg_t DEF_CFG = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [3:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic          commit,
    output cfg_t          cfg_act
);

    typedef struct packed {
        cfg_t shadow;
        cfg_t active;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (commit) begin
            r_d.active = r_q.shadow;
        end
        if (wr_en) begin
            case (wr_addr)
                REG_HTOT:   r_d.shadow.htot       = wr_data;
                REG_HACT:   r_d.shadow.hact       = wr_data;
                REG_HS_BEG: r_d.shadow.hs_beg     = wr_data;
                REG_HS_END: r_d.shadow.hs_end     = wr_data;
                REG_VTOT0:  r_d.shadow.vtot0      = wr_data;
                REG_VTOT1:  r_d.shadow.vtot1      = wr_data;
                REG_VACT:   r_d.shadow.vact       = wr_data;
                REG_VS_BEG: r_d.shadow.vs_beg     = wr_data;
                REG_VS_END: r_d.shadow.vs_end     = wr_data;
                REG_FLINE:  r_d.shadow.fline      = wr_data;
                REG_MODE:   r_d.shadow.interlaced = wr_data[0];
                REG_RST_H:  r_d.shadow.rst_h      = wr_data;
                REG_RST_V:  r_d.shadow.rst_v      = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.shadow <= DEF_CFG;
            r_q.active <= DEF_CFG;
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_act = r_q.active;

endmodule

// File: rtl/rtg_lane_pos.sv
module rtg_lane_pos
    import raster_timing_pkg::*;
#(
    parameter int OFFSET  = 0,
    parameter bit NO_WRAP = 1'b0
) (
    input  pos_t base,
    input  cfg_t cfg,
    output pos_t pos,
    output logic frame_wrap
);

    localparam logic [CW:0] OFS = (CW+1)'(OFFSET);

    generate
        if (NO_WRAP) begin : g_nowrap
            always_comb begin
                pos        = base;
                pos.pix    = base.pix + OFS[CW-1:0];
                frame_wrap = 1'b0;
            end
        end else begin : g_wrap
            logic [CW:0]   sum;
            logic [CW:0]   nxt_line;
            logic [CW-1:0] ftot;
            always_comb begin
                sum        = {1'b0, base.pix} + OFS;
                nxt_line   = {1'b0, base.line} + (CW+1)'(1);
                ftot       = base.fld ? cfg.vtot1 : cfg.vtot0;
                pos        = base;
                frame_wrap = 1'b0;
                if (sum >= {1'b0, cfg.htot}) begin
                    pos.pix = CW'(sum - {1'b0, cfg.htot});
                    if (nxt_line >= {1'b0, ftot}) begin
                        pos.line   = '0;
                        pos.fld    = cfg.interlaced ? ~base.fld : 1'b0;
                        frame_wrap = ~(cfg.interlaced & ~base.fld);
                    end else begin
                        pos.line = nxt_line[CW-1:0];
                    end
                end else begin
                    pos.pix = sum[CW-1:0];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/rtg_lane_flags.sv
module rtg_lane_flags
    import raster_timing_pkg::*;
(
    input  pos_t              pos,
    input  cfg_t              cfg,
    output logic [CTRL_W-1:0] ctrl,
    output logic              f_out,
    output logic              v_out,
    output logic              h_out
);

    always_comb begin
        ctrl           = '0;
        ctrl[CTRL_ACT] = (pos.pix < cfg.hact) && (pos.line < cfg.vact);
        ctrl[CTRL_SOL] = (pos.pix == '0);
        ctrl[CTRL_SOF] = (pos.pix == '0) && (pos.line == '0) && !pos.fld;
        ctrl[CTRL_EOL] = (pos.pix == cfg.htot - CW'(1));
        h_out          = (pos.pix >= cfg.hs_beg) && (pos.pix < cfg.hs_end);
        v_out          = (pos.line >= cfg.vs_beg) && (pos.line < cfg.vs_end);
        f_out          = cfg.interlaced && (pos.fld ^ (pos.line >= cfg.fline));
    end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import raster_timing_pkg::*;
#(
    parameter int LANES      = 4,
    parameter bit ALIGNED    = 1'b0,
    parameter int H_TOTAL    = 11,
    parameter int H_ACTIVE   = 8,
    parameter int HS_BEG     = 9,
    parameter int HS_END     = 10,
    parameter int V_TOTAL0   = 5,
    parameter int V_TOTAL1   = 6,
    parameter int V_ACTIVE   = 3,
    parameter int VS_BEG     = 3,
    parameter int VS_END     = 4,
    parameter int F_LINE     = 2,
    parameter bit INTERLACED = 1'b0,
    parameter int RESTART_H  = 3,
    parameter int RESTART_V  = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [3:0]              cfg_addr,
    input  logic [CW-1:0]           cfg_wdata,
    input  logic                    restart,
    output logic [LANES*CTRL_W-1:0] ctrl_word,
    output logic [LANES-1:0]        f_flag,
    output logic [LANES-1:0]        v_flag,
    output logic [LANES-1:0]        h_flag
);

    localparam cfg_t DEF_CFG = '{
        htot:   CW'(H_TOTAL),  hact:   CW'(H_ACTIVE),
        hs_beg: CW'(HS_BEG),   hs_end: CW'(HS_END),
        vtot0:  CW'(V_TOTAL0), vtot1:  CW'(V_TOTAL1),
        vact:   CW'(V_ACTIVE), vs_beg: CW'(VS_BEG),
        vs_end: CW'(VS_END),   fline:  CW'(F_LINE),
        interlaced: INTERLACED,
        rst_h:  CW'(RESTART_H), rst_v: CW'(RESTART_V)
    };

    typedef struct packed {
        pos_t base;
    } state_t;

    state_t st_d, st_q;
    cfg_t   cfg;
    pos_t   next_base;
    logic   frame_wrap;
    logic   commit;
    logic [LANES-1:0] sol_vec;

    rtg_cfg_regs #(.DEF_CFG(DEF_CFG)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .commit  (commit),
        .cfg_act (cfg)
    );

    rtg_lane_pos #(.OFFSET(LANES), .NO_WRAP(1'b0)) i_next (
        .base       (st_q.base),
        .cfg        (cfg),
        .pos        (next_base),
        .frame_wrap (frame_wrap)
    );

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            pos_t lpos;
            logic lwrap;
            logic [CTRL_W-1:0] lctrl;

            rtg_lane_pos #(.OFFSET(k), .NO_WRAP(ALIGNED)) i_pos (
                .base       (st_q.base),
                .cfg        (cfg),
                .pos        (lpos),
                .frame_wrap (lwrap)
            );

            rtg_lane_flags i_flags (
                .pos   (lpos),
                .cfg   (cfg),
                .ctrl  (lctrl),
                .f_out (f_flag[k]),
                .v_out (v_flag[k]),
                .h_out (h_flag[k])
            );

            assign ctrl_word[k*CTRL_W +: CTRL_W] = lctrl;
            assign sol_vec[k] = lctrl[CTRL_SOL];

            AST_LANE_PIX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
                lpos.pix < cfg.htot) else $error("lane pixel out of line"); // R2
        end
    endgenerate

    always_comb begin
        st_d   = st_q;
        commit = frame_wrap && !restart;
        if (restart) begin
            st_d.base.pix  = cfg.rst_h;
            st_d.base.line = cfg.rst_v;
            st_d.base.fld  = 1'b0;
        end else begin
            st_d.base = next_base;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_ONE_LINE_START: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sol_vec) <= 1) else $error("two line starts in one word"); // R2
    AST_RESTART_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.base.pix == $past(cfg.rst_h)) && (st_q.base.line == $past(cfg.rst_v))
                    && !st_q.base.fld) else $error("restart missed"); // R10
    AST_COMMIT_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (st_q.base.line == '0) && !st_q.base.fld) else $error("commit off frame start"); // R9
    AST_PROG_FIELD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.interlaced |-> !st_q.base.fld) else $error("field set in progressive"); // R7
    AST_LINE_IN_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.base.line < (st_q.base.fld ? cfg.vtot1 : cfg.vtot0)) else $error("line beyond field"); // R8

endmodule

// File: tb/test_raster_timing_gen.sv
`timescale 1ns/1ps
module test_raster_timing_gen;
    localparam int LANES = 4;
    localparam int CW    = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [CW-1:0] cfg_wdata = '0;
    logic restart = 1'b0;
    logic [LANES*4-1:0] ctrl_word;
    logic [LANES-1:0] f_flag, v_flag, h_flag;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    raster_timing_gen i_raster_timing_gen (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .restart(restart), .ctrl_word(ctrl_word),
        .f_flag(f_flag), .v_flag(v_flag), .h_flag(h_flag)
    );

    always #2.5 clk = ~clk;

    // reference model: active and shadow geometry by register address
    int act[13];
    int shd[13];
    int m_pix, m_line, m_fld;

    function automatic int ftot(input int f);
        return f ? act[5] : act[4];
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at t=%0t", tag, got, exp, $time);
        end
    endtask

    // one pixel step; returns 1 when the raster wrapped to field 0 line 0
    task automatic step(inout int p, inout int l, inout int f, output bit wrapped);
        wrapped = 0;
        p++;
        if (p >= act[0]) begin
            p = 0;
            l++;
            if (l >= ftot(f)) begin
                l = 0;
                f = act[10] ? (f ^ 1) : 0;
                wrapped = (f == 0);
            end
        end
    endtask

    task automatic compare_word(input string tag);
        int p, l, f;
        bit w;
        p = m_pix; l = m_line; f = m_fld;
        for (int k = 0; k < LANES; k++) begin
            int e_act, e_sol, e_sof, e_eol, e_h, e_v, e_f;
            e_act = (p < act[1]) && (l < act[6]);
            e_sol = (p == 0);
            e_sof = (p == 0) && (l == 0) && (f == 0);
            e_eol = (p == act[0] - 1);
            e_h   = (p >= act[2]) && (p < act[3]);
            e_v   = (l >= act[7]) && (l < act[8]);
            e_f   = act[10] ? (f ^ int'(l >= act[9])) : 0;
            check({tag, " R3 active"}, ctrl_word[k*4+0], e_act);
            if (k > 0 && e_sol) check({tag, " R2 mid-word line start"}, ctrl_word[k*4+1], e_sol);
            else                check({tag, " R6 line start"}, ctrl_word[k*4+1], e_sol);
            check({tag, " R6 frame start"}, ctrl_word[k*4+2], e_sof);
            check({tag, " R6 line end"}, ctrl_word[k*4+3], e_eol);
            check({tag, " R4 hflag"}, h_flag[k], e_h);
            check({tag, " R5 vflag"}, v_flag[k], e_v);
            if (act[10]) check({tag, " R8 fflag"}, f_flag[k], e_f);
            else         check({tag, " R7 fflag"}, f_flag[k], e_f);
            step(p, l, f, w);
        end
    endtask

    // called at a negedge: drive inputs for the coming edge, check, update model
    task automatic tick(input string tag, input bit we, input int addr, input int data, input bit rs);
        bit any_wrap, w;
        cfg_we = we; cfg_addr = 4'(addr); cfg_wdata = CW'(data); restart = rs;
        compare_word(tag);
        if (rs) begin
            m_pix = act[11]; m_line = act[12]; m_fld = 0;
        end else begin
            any_wrap = 0;
            for (int k = 0; k < LANES; k++) begin
                step(m_pix, m_line, m_fld, w);
                any_wrap |= w;
            end
            if (any_wrap) act = shd;
        end
        if (we) shd[addr] = data;
        @(negedge clk);
        cfg_we = 1'b0; restart = 1'b0;
    endtask

    task automatic run(input string tag, input int n);
        for (int i = 0; i < n; i++) tick(tag, 0, 0, 0, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        act = '{11, 8, 9, 10, 5, 6, 3, 3, 4, 2, 0, 3, 1};
        shd = act;
        m_pix = 0; m_line = 0; m_fld = 0;
        check("R1 reset control word lane0", ctrl_word[3:0], 4'b0111);
        check("R1 reset field flags", f_flag, 0);
        run("R1", 2);
    endtask

    task automatic t_restart();
        tick("R10 before", 0, 0, 0, 1);
        check("R10 lane0 after restart (pix3 line1)", ctrl_word[3:0], 4'b0001);
        run("R10 after", 20);
    endtask

    task automatic t_progressive();
        run("R7 progressive", 40);
    endtask

    task automatic t_shadow();
        tick("R9 write", 1, 0, 13, 0);
        tick("R9 write", 1, 1, 10, 0);
        tick("R9 write", 1, 3, 12, 0);
        run("R9 old geometry then new", 50);
    endtask

    task automatic t_interlace();
        tick("R8 write", 1, 10, 1, 0);
        tick("R8 write", 1, 9, 3, 0);
        run("R8 interlaced", 100);
        tick("R8 restart in field", 0, 0, 0, 1);
        run("R8 after restart", 40);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_restart();
        t_progressive();
        t_shadow();
        t_interlace();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected below 20000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule